// File: doc/BRIEF.md
# NaN Classify and Quiet Unit

This block looks at one 64-bit double-precision word and reports its class: zero, denormal, normal, infinity, quiet NaN or signaling NaN. A mode input selects the NaN encoding. With `nan2008` high, the newer convention applies, where a set top fraction bit marks a quiet NaN. With `nan2008` low, the legacy convention applies, where the sense of that bit is inverted.

When the operand is a signaling NaN, the block outputs the quieted NaN and raises an invalid-operation flag. Every other operand passes through bit for bit, with the flag low. The parameter `LEGACY_INDEF` selects the legacy quieting behaviour:

- With `LEGACY_INDEF = 0`, the payload is kept.
- With `LEGACY_INDEF = 1`, the operand is replaced by the default indefinite NaN.

The parameter `REGISTER_OUT` adds one output register stage. Without it, the outputs follow the inputs combinationally and `outValid` mirrors `inValid`.

Top module: `nan_quiet_unit`

## Requirements
- R1: `classOut` encodes the operand class as follows. 0 is zero (exponent field 0, fraction 0). 1 is denormal (exponent field 0, fraction nonzero). 2 is normal (any other exponent field). 3 is infinity (exponent field all ones, fraction 0). 4 is quiet NaN and 5 is signaling NaN; both have the exponent field all ones and a nonzero fraction.
- R2: A NaN is signaling exactly when `nan2008` XOR bit 51 equals 1. In 2008 mode a clear bit 51 means signaling. In legacy mode a set bit 51 means signaling.
- R3: `invalidOut` is 1 exactly when the operand is a signaling NaN.
- R4: In 2008 mode, a signaling NaN is output with bit 51 set and every other bit (sign, exponent, remaining payload) unchanged.
- R5: In legacy mode with `LEGACY_INDEF = 0`, a signaling NaN is output with bit 51 cleared. If fraction bits 50..0 are then all zero, bit 50 is set.
- R6: In legacy mode with `LEGACY_INDEF = 1`, a signaling NaN is replaced by 0x7FF7_FFFF_FFFF_FFFF.
- R7: Any operand that is not a signaling NaN appears on `resOut` unchanged, with `invalidOut` at 0.
- R8: With `REGISTER_OUT = 1`, the following hold:
  - The result, class and flag appear one clock after a cycle with `inValid` high.
  - `outValid` is high in that cycle only.
  - After reset, `outValid` and `invalidOut` are 0.
- R9: A quieted result always has the exponent field all ones and a nonzero fraction, so it never becomes an infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| opIn | input | 64 | Double-precision operand |
| nan2008 | input | 1 | 1 selects 2008 NaN encoding, 0 selects legacy encoding |
| outValid | output | 1 | Result strobe |
| resOut | output | 64 | Quieted or passed-through word |
| classOut | output | 3 | Class code per R1 |
| invalidOut | output | 1 | Invalid-operation flag |

## Verification
The assertions assume three things:

- `nan2008` stays steady for each operand.
- `opIn` and `nan2008` are sampled only in cycles where `inValid` is high.
- The flag and result are compared against the operand captured in the previous cycle.

The bench drives each operand and its mode together on a falling edge and holds them for a full clock. It drops `inValid` between operands, so every output strobe maps to exactly one operand. A second instance uses the combinational, indefinite-NaN variant and receives the same stimulus.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } nanq_class_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setQbit;   // 2008-style quieting
    logic clrQbit;   // legacy-style quieting
  } nanq_strobe_t;

endpackage

// File: rtl/nanq_control.sv
module nanq_control
  import nanq_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]  expField,
  input  logic [FRAC_W-1:0] fracField,
  input  logic              nan2008,
  output nanq_class_e       classCode,
  output nanq_strobe_t      strobes
);

  localparam int QBIT = FRAC_W - 1;

  logic expZero;
  logic expOnes;
  logic fracZero;
  logic sigNan;

  assign expZero  = (expField == '0);
  assign expOnes  = (&expField);
  assign fracZero = (fracField == '0);
  assign sigNan   = expOnes && !fracZero && (nan2008 ^ fracField[QBIT]);

  always_comb begin
    if (expZero)      classCode = fracZero ? CLS_ZERO : CLS_DENORM;
    else if (!expOnes) classCode = CLS_NORMAL;
    else if (fracZero) classCode = CLS_INF;
    else if (sigNan)   classCode = CLS_SNAN;
    else               classCode = CLS_QNAN;
  end

  always_comb begin
    strobes.setQbit = sigNan && nan2008;
    strobes.clrQbit = sigNan && !nan2008;
  end

endmodule

// File: rtl/nanq_datapath.sv
module nanq_datapath
  import nanq_pkg::*;
#(
  parameter int EXP_W        = 11,
  parameter int FRAC_W       = 52,
  parameter bit REGISTER_OUT = 1'b1,
  parameter bit LEGACY_INDEF = 1'b0,
  localparam int WORD_W      = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opWord,
  input  nanq_strobe_t      strobes,
  input  nanq_class_e       classIn,
  output logic              outValid,
  output logic [WORD_W-1:0] resOut,
  output logic [2:0]        classOut,
  output logic              invalidOut
);

  localparam int QBIT = FRAC_W - 1;
  localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << QBIT;
  localparam logic [WORD_W-1:0] NEXT_MASK = WORD_W'(1) << (QBIT - 1);
  localparam logic [WORD_W-1:0] INDEF_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic [WORD_W-1:0] legacyWord;
  logic [WORD_W-1:0] quietWord;
  logic              flagNow;

  generate
    if (LEGACY_INDEF) begin : g_indef
      assign legacyWord = INDEF_WORD;
    end else begin : g_keep
      logic [WORD_W-1:0] cleared;
      assign cleared    = opWord & ~QMASK;
      assign legacyWord = (cleared[FRAC_W-1:0] == '0) ? (cleared | NEXT_MASK) : cleared;
    end
  endgenerate

  always_comb begin
    quietWord = opWord;
    if (strobes.setQbit)      quietWord = opWord | QMASK;
    else if (strobes.clrQbit) quietWord = legacyWord;
  end

  assign flagNow = strobes.setQbit | strobes.clrQbit;

  generate
    if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid   <= 1'b0;
          resOut     <= '0;
          classOut   <= 3'd0;
          invalidOut <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            resOut     <= quietWord;
            classOut   <= classIn;
            invalidOut <= flagNow;
          end
        end
      end

      a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      a_r8_single: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      a_r7_passthrough: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && !invalidOut) |-> (resOut == $past(opWord)));
      a_r4_keep_payload: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && invalidOut && $past(strobes.setQbit)) |->
          (resOut[QBIT] && ((resOut | QMASK) == ($past(opWord) | QMASK))));
    end else begin : g_comb
      assign outValid   = inValid;
      assign resOut     = quietWord;
      assign classOut   = classIn;
      assign invalidOut = flagNow;

      a_r7_passthrough: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && !invalidOut) |-> (resOut == opWord));
    end
  endgenerate

  a_r9_still_nan: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidOut) |->
      ((&resOut[WORD_W-2:FRAC_W]) && (resOut[FRAC_W-1:0] != '0)));
  a_r3_flag_class: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (invalidOut == (classOut == 3'd5)));

endmodule

// File: rtl/nan_quiet_unit.sv
module nan_quiet_unit
  import nanq_pkg::*;
#(
  parameter int EXP_W        = 11,
  parameter int FRAC_W       = 52,
  parameter bit REGISTER_OUT = 1'b1,
  parameter bit LEGACY_INDEF = 1'b0,
  localparam int WORD_W      = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opIn,
  input  logic              nan2008,
  output logic              outValid,
  output logic [WORD_W-1:0] resOut,
  output logic [2:0]        classOut,
  output logic              invalidOut
);

  nanq_class_e  classCode;
  nanq_strobe_t strobes;

  nanq_control #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ctrl (
    .expField  (opIn[WORD_W-2:FRAC_W]),
    .fracField (opIn[FRAC_W-1:0]),
    .nan2008   (nan2008),
    .classCode (classCode),
    .strobes   (strobes)
  );

  nanq_datapath #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W),
    .REGISTER_OUT(REGISTER_OUT), .LEGACY_INDEF(LEGACY_INDEF)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opWord     (opIn),
    .strobes    (strobes),
    .classIn    (classCode),
    .outValid   (outValid),
    .resOut     (resOut),
    .classOut   (classOut),
    .invalidOut (invalidOut)
  );

endmodule

// File: tb/nan_quiet_unit_tb.sv
`timescale 1ns/1ps
module nan_quiet_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opIn = '0;
  logic        nan2008 = 1'b0;

  logic        outValid, invalidOut;
  logic [63:0] resOut;
  logic [2:0]  classOut;

  logic        outValidB, invalidOutB;
  logic [63:0] resOutB;
  logic [2:0]  classOutB;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nan_quiet_unit #(.REGISTER_OUT(1'b1), .LEGACY_INDEF(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opIn(opIn), .nan2008(nan2008),
    .outValid(outValid), .resOut(resOut), .classOut(classOut), .invalidOut(invalidOut)
  );

  nan_quiet_unit #(.REGISTER_OUT(1'b0), .LEGACY_INDEF(1'b1)) u_dutIndef (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opIn(opIn), .nan2008(nan2008),
    .outValid(outValidB), .resOut(resOutB), .classOut(classOutB), .invalidOut(invalidOutB)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected model written from the requirements
  function automatic logic [2:0] expClass(input logic [63:0] w, input logic m);
    logic [10:0] e = w[62:52];
    logic [51:0] f = w[51:0];
    if (e == 0) return (f == 0) ? 3'd0 : 3'd1;
    if (e != 11'h7FF) return 3'd2;
    if (f == 0) return 3'd3;
    return (m ^ f[51]) ? 3'd5 : 3'd4;
  endfunction

  function automatic logic [63:0] expRes(input logic [63:0] w, input logic m, input bit indef);
    logic [63:0] r;
    if (expClass(w, m) != 3'd5) return w;
    if (m) return w | (64'd1 << 51);
    if (indef) return 64'h7FF7_FFFF_FFFF_FFFF;
    r = w & ~(64'd1 << 51);
    if (r[50:0] == 0) r[50] = 1'b1;
    return r;
  endfunction

  task automatic run_case(input string req, input logic [63:0] w, input logic m);
    @(negedge clk);
    opIn = w; nan2008 = m; inValid = 1'b1;
    #1;
    chk({req, " comb res"},   resOutB, expRes(w, m, 1'b1));
    chk({req, " comb class"}, 64'(classOutB), 64'(expClass(w, m)));
    chk({req, " comb flag"},  64'(invalidOutB), 64'(expClass(w, m) == 3'd5));
    @(negedge clk);
    chk({req, " R8 valid"}, 64'(outValid), 64'd1);
    chk({req, " res"},      resOut, expRes(w, m, 1'b0));
    chk({req, " class"},    64'(classOut), 64'(expClass(w, m)));
    chk({req, " flag"},     64'(invalidOut), 64'(expClass(w, m) == 3'd5));
    inValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset valid", 64'(outValid), 64'd0);
    chk("R8 reset flag",  64'(invalidOut), 64'd0);
  endtask

  task automatic t_classes();
    run_case("R1 R7 zero",     64'h0000_0000_0000_0000, 1'b1);
    run_case("R1 R7 negzero",  64'h8000_0000_0000_0000, 1'b0);
    run_case("R1 R7 denorm",   64'h800F_0000_0000_0001, 1'b1);
    run_case("R1 R7 normal",   64'h3FF0_0000_0000_0000, 1'b0);
    run_case("R1 R7 inf",      64'h7FF0_0000_0000_0000, 1'b1);
    run_case("R1 R7 neginf",   64'hFFF0_0000_0000_0000, 1'b0);
  endtask

  task automatic t_sense();
    run_case("R2 R7 qnan2008",   64'h7FF8_0000_0000_0000, 1'b1);
    run_case("R2 R7 qnanlegacy", 64'h7FF0_0000_0000_0001, 1'b0);
  endtask

  task automatic t_quiet2008();
    run_case("R4 R3 snan2008 min",     64'h7FF0_0000_0000_0001, 1'b1);
    run_case("R4 R3 snan2008 payload", 64'hFFF5_1234_5678_9ABC, 1'b1);
  endtask

  task automatic t_quietLegacy();
    run_case("R5 R6 R9 legacy bare", 64'h7FF8_0000_0000_0000, 1'b0);
    run_case("R5 R6 legacy payload", 64'hFFFC_0000_DEAD_BEEF, 1'b0);
    run_case("R5 R9 legacy bit50",   64'h7FFC_0000_0000_0000, 1'b0);
  endtask

  task automatic t_gap();
    @(negedge clk);
    chk("R8 single cycle", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_classes();
    t_sense();
    t_quiet2008();
    t_quietLegacy();
    t_gap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule